// File: doc/BRIEF.md
# Dual-Mode Processor Flag Register

This block keeps the condition and mode flags of a CPU core that starts in an 8-bit-compatible mode and can be switched into a wider native mode. It stores eight flag bits that software can see as one status byte, and a ninth emulation-mode bit that never appears in that byte. The only route to the mode bit is a one-cycle exchange with the carry flag. Software therefore loads carry with the wanted mode and then issues the exchange.

The mode bit changes what two status-byte positions mean. In native mode, bits 5 and 4 are the accumulator-width (m) and index-width (x) flags. In emulation mode both are held at 1. Bit 5 then reads as the always-one position, and bit 4 becomes a break marker that exists only in the byte saved for an interrupt or break entry. The block also tells the fetch logic which vector an entry should use. Emulation mode shares one vector between hardware interrupts and break instructions. Native mode gives each its own vector.

The flag bits, from bit 7 down to bit 0, are: N, V, m, x, D, I, Z, C.

The restore path is a single valid strobe, `pull_valid`. The block accepts a pulled byte on any cycle and never applies back-pressure. The save path is combinational: `push_byte` is valid in any cycle where `save_req` is high.

Top module: `cpu_flag_unit`

## Requirements
- R1: Reset puts the block in the following state: emulation mode (`e_mode` = 1), status byte 0x34 (m, x and I set, every other flag clear), and vector code 3.
- R2: While `pull_valid` is low, `xchg_ce` swaps carry (bit 0) and the emulation bit in one clock edge.
- R3: While `e_mode` is 1, status bits 5 and 4 read as 1. This includes the cycle right after an exchange that enters emulation mode. Set or clear commands on those bits have no effect in emulation mode.
- R4: A set or clear command on a bit overrides an ALU update of the same bit in the same cycle. If a bit is both set and cleared in one cycle, set wins.
- R5: In emulation mode, `push_byte` has bit 5 = 1 and bit 4 = `save_is_brk`. Every other bit equals the status byte.
- R6: In native mode, `push_byte` equals the status byte exactly.
- R7: A pull in emulation mode loads bits 7:6 and 3:0 from `pull_byte`. Bits 5 and 4 of the pulled byte are ignored and stay 1.
- R8: A pull in native mode loads all 8 bits from `pull_byte`. A pull overrides the exchange, the set and clear commands, and the ALU updates in the same cycle.
- R9: On the edge after `save_req`, `vec_code` becomes one of three values: 0 in emulation mode (IRQ and BRK share it), 1 for a native IRQ, or 2 for a native BRK. Without `save_req`, `vec_code` holds its value.
- R10: An exchange when carry already equals the emulation bit leaves the status byte and the mode unchanged.
- R11: ALU update lanes 3, 2, 1 and 0 write N (bit 7), V (bit 6), Z (bit 1) and C (bit 0). Each lane writes only when its write enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_we | input | 4 | ALU flag write enables, lanes {N,V,Z,C} |
| alu_val | input | 4 | ALU flag values, lanes {N,V,Z,C} |
| set_mask | input | 8 | Bits to force to 1 |
| clr_mask | input | 8 | Bits to force to 0 |
| xchg_ce | input | 1 | Swap carry with emulation bit |
| pull_valid | input | 1 | Restore strobe, always accepted |
| pull_byte | input | 8 | Byte to restore |
| save_req | input | 1 | Interrupt/break entry is saving state |
| save_is_brk | input | 1 | Entry source is a break instruction |
| status_byte | output | 8 | Readable flag byte |
| e_mode | output | 1 | Emulation-mode bit |
| push_byte | output | 8 | Byte to save, valid with `save_req` |
| vec_code | output | 2 | Vector selection code |

## Verification
`push_byte` is combinational and belongs to the same cycle as `save_req`. The bench drives the request one time unit after a rising edge and reads the byte before the next edge.

The flag byte, the mode bit and `vec_code` are registered, so each is due on the first rising edge after its command. The bench samples them one time unit after that edge and then returns the inputs to idle. This keeps every result tied to exactly one command.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned ALU_W  = 4;
  localparam int unsigned VEC_W  = 2;

  localparam int unsigned BIT_N = 7;
  localparam int unsigned BIT_V = 6;
  localparam int unsigned BIT_M = 5;
  localparam int unsigned BIT_X = 4;
  localparam int unsigned BIT_D = 3;
  localparam int unsigned BIT_I = 2;
  localparam int unsigned BIT_Z = 1;
  localparam int unsigned BIT_C = 0;

  localparam logic [FLAG_W-1:0] FLAG_RESET = 8'h34;

  typedef enum logic [VEC_W-1:0] {
    VEC_EMU_SHARED = 2'd0,
    VEC_NAT_IRQ    = 2'd1,
    VEC_NAT_BRK    = 2'd2,
    VEC_RESET      = 2'd3
  } vec_code_e;

  // ALU lane to status-byte position: lane0 C, lane1 Z, lane2 V, lane3 N
  function automatic int unsigned alu_lane_pos(input int unsigned lane);
    case (lane)
      0:       return BIT_C;
      1:       return BIT_Z;
      2:       return BIT_V;
      default: return BIT_N;
    endcase
  endfunction
endpackage

// File: rtl/flag_next_logic.sv
module flag_next_logic
  import flagreg_pkg::*;
(
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic              cur_e,
  input  logic [ALU_W-1:0]  alu_we,
  input  logic [ALU_W-1:0]  alu_val,
  input  logic [FLAG_W-1:0] set_mask,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic              xchg_ce,
  input  logic              pull_valid,
  input  logic [FLAG_W-1:0] pull_byte,
  output logic [FLAG_W-1:0] nxt_flags,
  output logic              nxt_e
);
  logic [FLAG_W-1:0] after_alu;
  logic [FLAG_W-1:0] after_cmd;
  logic [FLAG_W-1:0] after_src;

  // ALU lanes, lowest priority
  always_comb begin
    after_alu = cur_flags;
    for (int unsigned ln = 0; ln < ALU_W; ln++) begin
      if (alu_we[ln]) after_alu[alu_lane_pos(ln)] = alu_val[ln];
    end
  end

  // explicit commands beat the ALU; set beats clear
  assign after_cmd = (after_alu & ~clr_mask) | set_mask;

  // a pull overrides everything; the exchange touches only carry and mode
  always_comb begin
    after_src = after_cmd;
    nxt_e     = cur_e;
    if (pull_valid) begin
      after_src = pull_byte;
    end else if (xchg_ce) begin
      after_src[BIT_C] = cur_e;
      nxt_e            = cur_flags[BIT_C];
    end
  end

  // width flags pinned high whenever the next mode is emulation
  always_comb begin
    nxt_flags = after_src;
    if (nxt_e) begin
      nxt_flags[BIT_M] = 1'b1;
      nxt_flags[BIT_X] = 1'b1;
    end
  end
endmodule

// File: rtl/flag_push_compose.sv
module flag_push_compose
  import flagreg_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic              e_bit,
  input  logic              is_brk,
  output logic [FLAG_W-1:0] push_byte
);
  always_comb begin
    push_byte = flags;
    if (e_bit) begin
      push_byte[BIT_M] = 1'b1;
      push_byte[BIT_X] = is_brk;
    end
  end
endmodule

// File: rtl/flag_vector_sel.sv
module flag_vector_sel
  import flagreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             save_is_brk,
  input  logic             e_bit,
  output logic [VEC_W-1:0] vec_code
);
  vec_code_e vec_q;
  vec_code_e vec_d;

  always_comb begin
    vec_d = vec_q;
    if (save_req) begin
      if (e_bit)            vec_d = VEC_EMU_SHARED;
      else if (save_is_brk) vec_d = VEC_NAT_BRK;
      else                  vec_d = VEC_NAT_IRQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= VEC_RESET;
    else        vec_q <= vec_d;
  end

  assign vec_code = vec_q;
endmodule

// File: rtl/cpu_flag_unit.sv
module cpu_flag_unit
  import flagreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ALU_W-1:0]  alu_we,
  input  logic [ALU_W-1:0]  alu_val,
  input  logic [FLAG_W-1:0] set_mask,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic              xchg_ce,
  input  logic              pull_valid,
  input  logic [FLAG_W-1:0] pull_byte,
  input  logic              save_req,
  input  logic              save_is_brk,
  output logic [FLAG_W-1:0] status_byte,
  output logic              e_mode,
  output logic [FLAG_W-1:0] push_byte,
  output logic [VEC_W-1:0]  vec_code
);
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] flag_d;
  logic              e_q;
  logic              e_d;

  flag_next_logic u_next (
    .cur_flags (flag_q),
    .cur_e     (e_q),
    .alu_we    (alu_we),
    .alu_val   (alu_val),
    .set_mask  (set_mask),
    .clr_mask  (clr_mask),
    .xchg_ce   (xchg_ce),
    .pull_valid(pull_valid),
    .pull_byte (pull_byte),
    .nxt_flags (flag_d),
    .nxt_e     (e_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= FLAG_RESET;
      e_q    <= 1'b1;
    end else begin
      flag_q <= flag_d;
      e_q    <= e_d;
    end
  end

  flag_push_compose u_push (
    .flags    (flag_q),
    .e_bit    (e_q),
    .is_brk   (save_is_brk),
    .push_byte(push_byte)
  );

  flag_vector_sel u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_req   (save_req),
    .save_is_brk(save_is_brk),
    .e_bit      (e_q),
    .vec_code   (vec_code)
  );

  assign status_byte = flag_q;
  assign e_mode      = e_q;
endmodule

// File: rtl/cpu_flag_unit_chk.sv
module cpu_flag_unit_chk
  import flagreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ALU_W-1:0]  alu_we,
  input logic [ALU_W-1:0]  alu_val,
  input logic [FLAG_W-1:0] set_mask,
  input logic [FLAG_W-1:0] clr_mask,
  input logic              xchg_ce,
  input logic              pull_valid,
  input logic [FLAG_W-1:0] pull_byte,
  input logic              save_req,
  input logic              save_is_brk,
  input logic [FLAG_W-1:0] status_byte,
  input logic              e_mode,
  input logic [FLAG_W-1:0] push_byte,
  input logic [VEC_W-1:0]  vec_code
);
  assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_ce && !pull_valid) |=> (e_mode == $past(status_byte[0])) && (status_byte[0] == $past(e_mode)));

  assert_width_pinned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    e_mode |-> (status_byte[5:4] == 2'b11));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask[3] && !pull_valid) |=> status_byte[3]);

  assert_emu_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && e_mode) |-> (push_byte[5] && (push_byte[4] == save_is_brk)));

  assert_native_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !e_mode) |-> (push_byte == status_byte));

  assert_native_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_valid && !e_mode) |=> (status_byte == $past(pull_byte)));

  assert_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> (vec_code == ($past(e_mode) ? 2'd0 : ($past(save_is_brk) ? 2'd2 : 2'd1))));

  assert_vector_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !save_req |=> $stable(vec_code));

  assert_alu_n_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we[3] && !set_mask[7] && !clr_mask[7] && !pull_valid) |=> (status_byte[7] == $past(alu_val[3])));
endmodule

bind cpu_flag_unit cpu_flag_unit_chk chk_i (.*);

// File: tb/cpu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module cpu_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] alu_we = '0, alu_val = '0;
  logic [7:0] set_mask = '0, clr_mask = '0, pull_byte = '0;
  logic       xchg_ce = 1'b0, pull_valid = 1'b0, save_req = 1'b0, save_is_brk = 1'b0;
  logic [7:0] status_byte, push_byte;
  logic       e_mode;
  logic [1:0] vec_code;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cpu_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_val(alu_val),
    .set_mask(set_mask), .clr_mask(clr_mask), .xchg_ce(xchg_ce),
    .pull_valid(pull_valid), .pull_byte(pull_byte), .save_req(save_req),
    .save_is_brk(save_is_brk), .status_byte(status_byte), .e_mode(e_mode),
    .push_byte(push_byte), .vec_code(vec_code)
  );

  // fields: alu_we, alu_val, set, clr, xchg, pull_v, pull_b, expected status, expected e
  localparam int NV = 13;
  localparam logic [42:0] TBL [NV] = '{
    {4'h0, 4'h0, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 8'h34, 1'b1}, // clear carry
    {4'h0, 4'h0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h35, 1'b0}, // R2 enter native
    {4'h0, 4'h0, 8'h00, 8'h30, 1'b0, 1'b0, 8'h00, 8'h05, 1'b0}, // widths cleared in native
    {4'hF, 4'hA, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h86, 1'b0}, // R11 N=1 V=0 Z=1 C=0
    {4'hF, 4'h0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 8'h05, 1'b0}, // R4 set beats ALU on C
    {4'h0, 4'h0, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b0}, // R8 native pull
    {4'h0, 4'h0, 8'h00, 8'hFF, 1'b1, 1'b1, 8'h0A, 8'h0A, 1'b0}, // R8 pull overrides
    {4'h0, 4'h0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0B, 1'b0}, // set carry
    {4'h0, 4'h0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h3A, 1'b1}, // R3 back to emulation
    {4'h0, 4'h0, 8'h00, 8'h00, 1'b0, 1'b1, 8'hC1, 8'hF1, 1'b1}, // R7 emulation pull
    {4'h0, 4'h0, 8'h00, 8'h30, 1'b0, 1'b0, 8'h00, 8'hF1, 1'b1}, // R3 clear ignored
    {4'h0, 4'h0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'hF1, 1'b1}, // R10 equal swap
    {4'h0, 4'h0, 8'h08, 8'h08, 1'b0, 1'b0, 8'h00, 8'hF9, 1'b1}  // R4 set beats clear
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_we = '0; alu_val = '0; set_mask = '0; clr_mask = '0;
    xchg_ce = 0; pull_valid = 0; pull_byte = '0; save_req = 0; save_is_brk = 0;
  endtask

  // inputs applied 1 ns after an edge; registered results read 1 ns after the next
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 status", status_byte, 8'h34);
    chk("R1 e_mode", {7'd0, e_mode}, 8'h01);
    chk("R1 vec", {6'd0, vec_code}, 8'h03);

    for (int i = 0; i < NV; i++) begin
      {alu_we, alu_val, set_mask, clr_mask, xchg_ce, pull_valid, pull_byte} = TBL[i][42:9];
      step();
      idle();
      chk($sformatf("table row %0d status", i), status_byte, TBL[i][8:1]);
      chk($sformatf("table row %0d e_mode", i), {7'd0, e_mode}, {7'd0, TBL[i][0]});
    end

    // emulation-mode saves, status F9
    save_req = 1; save_is_brk = 0; #1;
    chk("R5 irq push", push_byte, 8'hE9);
    save_is_brk = 1; #1;
    chk("R5 brk push", push_byte, 8'hF9);
    step(); idle();
    chk("R9 emu vec", {6'd0, vec_code}, 8'h00);

    // clear carry then exchange into native
    clr_mask = 8'h01; step(); idle();
    xchg_ce = 1; step(); idle();
    chk("R2 native status", status_byte, 8'hF9);
    chk("R2 native e", {7'd0, e_mode}, 8'h00);

    save_req = 1; save_is_brk = 0; #1;
    chk("R6 native push", push_byte, 8'hF9);
    step(); idle();
    chk("R9 native irq vec", {6'd0, vec_code}, 8'h01);
    save_req = 1; save_is_brk = 1;
    step(); idle();
    chk("R9 native brk vec", {6'd0, vec_code}, 8'h02);
    step();
    chk("R9 vec hold", {6'd0, vec_code}, 8'h02);

    // R11 lane isolation: only Z lane written
    alu_we = 4'b0010; alu_val = 4'b0000; step(); idle();
    chk("R11 Z lane only", status_byte, 8'hF9 & ~8'h02);

    // reset mid-run
    rst_n = 1'b0; #1;
    chk("R1 reset status", status_byte, 8'h34);
    chk("R1 reset e", {7'd0, e_mode}, 8'h01);
    chk("R1 reset vec", {6'd0, vec_code}, 8'h03);
    step(); rst_n = 1'b1; step();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule